// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block drives a small three-wire serial EEPROM that holds 64 sixteen-bit words. A host sends one request at a time, choosing an operation, a 6-bit word address and a 16-bit word to store. The block then runs the serial exchange on its chip select, shift clock and data lines. While the exchange runs, the busy output is high. The block reports completion with a one-cycle done pulse, and it keeps the most recent word read on its read-data output.

The block frames every request the same way. A command starts with a leading one, then a two-bit opcode, then the address, and it is shifted out most significant bit first. The data words in both directions travel least significant bit first. Writes and erases are self-timed inside the EEPROM, so the block polls the EEPROM's output line for a ready level and gives up after a bounded number of polls, raising an error. A boot request reads four consecutive words and builds a 48-bit station address from them.

The shift-clock half period is set by a parameter and counted in system clocks.

Top module: `uwire_rom_ctrl`

## Requirements
- R1: After reset, busy, done, err and stn_valid are 0, and ee_cs, ee_sk and ee_di are all 0.
- R2: A command is 9 bits sent most significant bit first. It is a 1, then the opcode, then the 6-bit address. The opcodes are read 10, write-enable 00, write 01 and erase 11. req_op selects the operation: 0 read, 1 write-enable, 2 write, 3 erase. ee_di changes only while ee_sk is low and is held steady across each rising edge.
- R3: A read clocks 16 bits from ee_do, sampling it at the end of each high half of ee_sk. The first bit received lands in rd_data bit 0, and rd_data holds the word once done pulses.
- R4: A write sends its 16 data bits right after the command, bit 0 first.
- R5: A write-enable ignores req_addr and sends 11 in the two upper address bits. Afterwards it drops ee_cs and gives exactly one ee_sk pulse with ee_cs low.
- R6: After the write data, or after the erase command, the block drops ee_cs and gives exactly one ee_sk pulse. It then raises ee_cs again and polls ee_do, with no further ee_sk pulses, until ee_do reads 1.
- R7: If ee_do stays 0 for POLL_MAX polls, err is set when done pulses. err clears when the next request is accepted.
- R8: Every access ends with ee_cs high and ee_di 0 for one half period, then all lines at 0. Whenever ee_cs falls, ee_sk and ee_di are 0.
- R9: busy is high from the cycle after a request is accepted until done. done lasts one cycle and is never high while busy. req_valid and boot_start are ignored while busy.
- R10: boot_start reads words BOOT_WORD to BOOT_WORD+3 and sets stn_valid when done pulses. For k = 0, 1, 2, let w be word BOOT_WORD+1+k and p be the word before it. Byte 2k of stn_addr, at bits [16k+7:16k], is the low 8 bits of (w<<1)|(p>>15). Byte 2k+1 is bits 14 to 7 of w. stn_valid clears when a boot is accepted.
- R11: Each high half of ee_sk lasts exactly HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 0 read, 1 write-enable, 2 write, 3 erase |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Word to write |
| boot_start | input | 1 | Starts the station-address boot read |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Write or erase poll timed out |
| rd_data | output | 16 | Last word read |
| stn_addr | output | 48 | Assembled station address, byte 0 in the low bits |
| stn_valid | output | 1 | stn_addr holds a completed boot result |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready level from the EEPROM |

## Verification
The hardest state to reach is the write-poll timeout. It needs a write that the EEPROM accepts but never finishes. The bench's EEPROM model has a stall switch that holds the ready line low after a write. The bench turns it on for one write and checks that err is reported. It then turns the switch off and checks that the next read clears err. A second hard case is a request that arrives while the block is busy. The bench drives an erase strobe in the middle of a read. It then checks, through the model's command count and a read-back, that the erase never reached the EEPROM.

// File: rtl/uw_pkg.sv
package uw_pkg;
    localparam int UW_ADDR_W = 6;
    localparam int UW_DATA_W = 16;
    localparam int UW_CMD_W  = UW_ADDR_W + 3;
    localparam int UW_STN_W  = 3 * UW_DATA_W;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WREN  = 2'd1,
        OP_WRITE = 2'd2,
        OP_ERASE = 2'd3
    } uw_op_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_CMD, ST_RDATA, ST_WDATA,
        ST_GAP, ST_POLL, ST_END1, ST_END2
    } uw_st_t;

    // Serial command: leading one, two opcode bits, word address.
    function automatic logic [UW_CMD_W-1:0] uw_cmd(input uw_op_t op,
                                                   input logic [UW_ADDR_W-1:0] a);
        case (op)
            OP_READ:  uw_cmd = {3'b110, a};
            OP_WREN:  uw_cmd = {3'b100, 2'b11, a[UW_ADDR_W-3:0]};
            OP_WRITE: uw_cmd = {3'b101, a};
            default:  uw_cmd = {3'b111, a};
        endcase
    endfunction
endpackage

// File: rtl/uw_tick_gen.sv
module uw_tick_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == CW'(HALF_DIV - 1));
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R11: a half period never reaches HALF_DIV counts
    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(HALF_DIV));
endmodule

// File: rtl/uw_addr_pack.sv
module uw_addr_pack
    import uw_pkg::*;
(
    input  logic [UW_DATA_W-1:0] cur_w,
    input  logic [UW_DATA_W-1:0] prev_w,
    output logic [7:0]           lo_byte,
    output logic [7:0]           hi_byte
);
    logic [UW_DATA_W-1:0] joined;

    always_comb begin
        joined  = {cur_w[UW_DATA_W-2:0], prev_w[UW_DATA_W-1]};
        lo_byte = joined[7:0];
        hi_byte = cur_w[14:7];
    end
endmodule

// File: rtl/uwire_rom_ctrl.sv
module uwire_rom_ctrl
    import uw_pkg::*;
#(
    parameter int HALF_DIV  = 4,
    parameter int POLL_MAX  = 4096,
    parameter int BOOT_WORD = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [UW_ADDR_W-1:0]  req_addr,
    input  logic [UW_DATA_W-1:0]  req_wdata,
    input  logic                  boot_start,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic [UW_DATA_W-1:0]  rd_data,
    output logic [UW_STN_W-1:0]   stn_addr,
    output logic                  stn_valid,
    output logic                  ee_cs,
    output logic                  ee_sk,
    output logic                  ee_di,
    input  logic                  ee_do
);
    localparam int CNT_W  = $clog2(UW_DATA_W);
    localparam int POLL_W = $clog2(POLL_MAX + 1);
    localparam int NBOOT  = 4;

    typedef struct packed {
        uw_st_t                 st;
        uw_op_t                 op;
        logic [UW_CMD_W-1:0]    cmd;
        logic [UW_DATA_W-1:0]   sh;
        logic                   phase;
        logic [CNT_W-1:0]       cnt;
        logic [POLL_W-1:0]      pcnt;
        logic                   cs;
        logic                   sk;
        logic                   di;
        logic                   done;
        logic                   err;
        logic [UW_DATA_W-1:0]   rdata;
        logic [UW_DATA_W-1:0]   prev;
        logic                   boot;
        logic [1:0]             bidx;
        logic [UW_STN_W-1:0]    stn;
        logic                   stn_vld;
    } regs_t;

    regs_t r_q, r_d;
    logic  tick;
    logic  accept;
    logic [UW_DATA_W-1:0] rd_word;
    logic [7:0] pk_lo, pk_hi;

    uw_tick_gen #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (r_q.st != ST_IDLE),
        .tick (tick)
    );

    assign rd_word = {ee_do, r_q.sh[UW_DATA_W-1:1]};

    uw_addr_pack i_pack (
        .cur_w  (rd_word),
        .prev_w (r_q.prev),
        .lo_byte(pk_lo),
        .hi_byte(pk_hi)
    );

    always_comb begin
        r_d    = r_q;
        r_d.done = 1'b0;
        accept = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                r_d.cs = 1'b0;
                r_d.sk = 1'b0;
                r_d.di = 1'b0;
                if (req_valid || boot_start) begin
                    accept  = 1'b1;
                    r_d.err = 1'b0;
                    r_d.st  = ST_START;
                    r_d.cs  = 1'b1;
                    if (req_valid) begin
                        r_d.op   = uw_op_t'(req_op);
                        r_d.boot = 1'b0;
                        r_d.cmd  = uw_cmd(uw_op_t'(req_op), req_addr);
                        r_d.sh   = req_wdata;
                    end else begin
                        r_d.op      = OP_READ;
                        r_d.boot    = 1'b1;
                        r_d.bidx    = '0;
                        r_d.stn_vld = 1'b0;
                        r_d.cmd     = uw_cmd(OP_READ, UW_ADDR_W'(BOOT_WORD));
                    end
                end
            end
            ST_START: if (tick) begin
                r_d.st    = ST_CMD;
                r_d.di    = r_q.cmd[UW_CMD_W-1];
                r_d.cnt   = '0;
                r_d.phase = 1'b0;
            end
            ST_CMD: if (tick) begin
                if (!r_q.phase) begin
                    r_d.sk    = 1'b1;
                    r_d.phase = 1'b1;
                end else begin
                    r_d.sk    = 1'b0;
                    r_d.phase = 1'b0;
                    if (r_q.cnt == CNT_W'(UW_CMD_W - 1)) begin
                        r_d.cnt = '0;
                        case (r_q.op)
                            OP_READ: begin
                                r_d.st = ST_RDATA;
                                r_d.di = 1'b0;
                            end
                            OP_WRITE: begin
                                r_d.st = ST_WDATA;
                                r_d.di = r_q.sh[0];
                                r_d.sh = r_q.sh >> 1;
                            end
                            default: begin
                                r_d.st = ST_GAP;
                                r_d.cs = 1'b0;
                                r_d.di = 1'b0;
                            end
                        endcase
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.di  = r_q.cmd[UW_CMD_W-2];
                        r_d.cmd = r_q.cmd << 1;
                    end
                end
            end
            ST_RDATA: if (tick) begin
                if (!r_q.phase) begin
                    r_d.sk    = 1'b1;
                    r_d.phase = 1'b1;
                end else begin
                    r_d.sk    = 1'b0;
                    r_d.phase = 1'b0;
                    r_d.sh    = rd_word;
                    if (r_q.cnt == CNT_W'(UW_DATA_W - 1)) begin
                        r_d.rdata = rd_word;
                        r_d.st    = ST_END1;
                        if (r_q.boot) begin
                            r_d.prev = rd_word;
                            case (r_q.bidx)
                                2'd1:    r_d.stn[15:0]  = {pk_hi, pk_lo};
                                2'd2:    r_d.stn[31:16] = {pk_hi, pk_lo};
                                2'd3:    r_d.stn[47:32] = {pk_hi, pk_lo};
                                default: ;
                            endcase
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_WDATA: if (tick) begin
                if (!r_q.phase) begin
                    r_d.sk    = 1'b1;
                    r_d.phase = 1'b1;
                end else begin
                    r_d.sk    = 1'b0;
                    r_d.phase = 1'b0;
                    if (r_q.cnt == CNT_W'(UW_DATA_W - 1)) begin
                        r_d.st = ST_GAP;
                        r_d.cs = 1'b0;
                        r_d.di = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.di  = r_q.sh[0];
                        r_d.sh  = r_q.sh >> 1;
                    end
                end
            end
            ST_GAP: if (tick) begin
                if (!r_q.phase) begin
                    r_d.sk    = 1'b1;
                    r_d.phase = 1'b1;
                end else begin
                    r_d.sk    = 1'b0;
                    r_d.phase = 1'b0;
                    r_d.cs    = 1'b1;
                    r_d.pcnt  = '0;
                    r_d.st    = (r_q.op == OP_WREN) ? ST_END1 : ST_POLL;
                end
            end
            ST_POLL: if (tick) begin
                if (ee_do) begin
                    r_d.st = ST_END1;
                end else if (r_q.pcnt == POLL_W'(POLL_MAX - 1)) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_END1;
                end else begin
                    r_d.pcnt = r_q.pcnt + 1'b1;
                end
            end
            ST_END1: if (tick) begin
                r_d.st = ST_END2;
                r_d.cs = 1'b0;
                r_d.di = 1'b0;
            end
            ST_END2: if (tick) begin
                if (r_q.boot && r_q.bidx != 2'(NBOOT - 1)) begin
                    r_d.bidx = r_q.bidx + 1'b1;
                    r_d.cmd  = uw_cmd(OP_READ, UW_ADDR_W'(BOOT_WORD)
                                      + UW_ADDR_W'(r_q.bidx) + 1'b1);
                    r_d.st   = ST_START;
                    r_d.cs   = 1'b1;
                end else begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    if (r_q.boot) r_d.stn_vld = 1'b1;
                    r_d.boot = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.op    <= OP_READ;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign err       = r_q.err;
    assign rd_data   = r_q.rdata;
    assign stn_addr  = r_q.stn;
    assign stn_valid = r_q.stn_vld;
    assign ee_cs     = r_q.cs;
    assign ee_sk     = r_q.sk;
    assign ee_di     = r_q.di;

    // R2: data line is steady across every shift-clock rise
    a_r2_di_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |-> $stable(ee_di));
    // R9: done is a single-cycle pulse and never overlaps busy
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8: lines rest low when idle
    a_r8_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ee_cs && !ee_sk && !ee_di));
    // R8: chip select falls with clock and data low
    a_r8_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |-> (!ee_sk && !ee_di));
    // R7: an accepted request clears the error flag
    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !err);
    // R10: station address becomes valid only at completion
    a_r10_stn_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stn_valid) |-> done);
endmodule

// File: tb/test_uwire_rom_ctrl.sv
module test_uwire_rom_ctrl;
    localparam int HD = 2;
    localparam int PM = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [5:0] req_addr = 6'd0;
    logic [15:0] req_wdata = 16'd0;
    logic boot_start = 1'b0;
    logic busy, done, err, stn_valid, ee_cs, ee_sk, ee_di;
    logic ee_do = 1'b0;
    logic [15:0] rd_data;
    logic [47:0] stn_addr;

    always #4 clk = ~clk;

    uwire_rom_ctrl #(.HALF_DIV(HD), .POLL_MAX(PM), .BOOT_WORD(6)) i_uwire_rom_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .boot_start(boot_start),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .stn_addr(stn_addr), .stn_valid(stn_valid), .ee_cs(ee_cs),
        .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int total = 0, bad = 0;
    int mon_total = 0, mon_bad = 0;

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [64];
    logic        stall = 1'b0;
    logic        wen = 1'b0;
    int          bitcnt = 0, busy_left = 0;
    logic [8:0]  cmd = '0, last_cmd = '0;
    logic [15:0] wbuf = '0;
    int          cmd_count = 0, gap_sk = 0, last_gap = 0;
    logic        pending = 1'b0, in_poll = 1'b0;
    int          poll_sk = 0, last_poll_sk = 0;
    int          hi_cnt = 0, sk_bad = 0, sk_pulses = 0;
    logic        sk_p = 1'b0, cs_p = 1'b0;

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'(16'h1357 + i * 16'h0203);
        mem[3]  = 16'h8001;
        mem[63] = 16'h5A3C;
        mem[6]  = 16'h8000;
        mem[7]  = 16'h12F5;
        mem[8]  = 16'hB3C7;
        mem[9]  = 16'h7E81;
    end

    always @(negedge clk) begin
        if (busy_left > 0 && !stall) busy_left--;
        if (ee_cs && !cs_p) begin
            bitcnt = 0;
            last_gap = gap_sk;
            gap_sk = 0;
            if (pending) begin in_poll = 1'b1; poll_sk = 0; end
        end
        if (!ee_cs && cs_p) begin
            if (in_poll) begin
                in_poll = 1'b0; pending = 1'b0; last_poll_sk = poll_sk;
            end else if (bitcnt >= 9) begin
                last_cmd = cmd;
                cmd_count++;
                if (cmd[8:6] == 3'b100 && cmd[5:4] == 2'b11) wen = 1'b1;
                if (wen && ((cmd[8:6] == 3'b101 && bitcnt == 25) || cmd[8:6] == 3'b111)) begin
                    mem[cmd[5:0]] = (cmd[8:6] == 3'b111) ? 16'hFFFF : wbuf;
                    busy_left = 30; pending = 1'b1; ee_do = 1'b0;
                end
            end
        end
        if (ee_sk && !sk_p) begin
            sk_pulses++;
            if (!ee_cs) gap_sk++;
            else if (in_poll) poll_sk++;
            else begin
                if (bitcnt < 9) cmd = {cmd[7:0], ee_di};
                else if (cmd[8:6] == 3'b110 && bitcnt < 25) ee_do = mem[cmd[5:0]][bitcnt-9];
                else if (cmd[8:6] == 3'b101 && bitcnt < 25) wbuf[bitcnt-9] = ee_di;
                bitcnt++;
            end
        end
        if (in_poll) ee_do = (busy_left == 0) && !stall;
        if (ee_sk) hi_cnt++;
        else if (sk_p) begin
            if (hi_cnt != HD) sk_bad++;
            hi_cnt = 0;
        end
        sk_p = ee_sk;
        cs_p = ee_cs;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          chk_data;
        logic [15:0] data;
        logic        err;
        string       tag;
    } exp_t;
    exp_t q[$];

    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                mon_total++; mon_bad++;
                $display("FAIL R9 unexpected done act=1 exp=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                mon_total++;
                if (err !== e.err) begin
                    mon_bad++;
                    $display("FAIL %s err act=%0b exp=%0b", e.tag, err, e.err);
                end
                if (e.chk_data) begin
                    mon_total++;
                    if (rd_data !== e.data) begin
                        mon_bad++;
                        $display("FAIL %s rd_data act=%h exp=%h", e.tag, rd_data, e.data);
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
        @(negedge clk);
    endtask

    task automatic run(input logic [1:0] op, input logic [5:0] a, input logic [15:0] wd,
                       input bit cd, input logic [15:0] ed, input logic ee, input string tag);
        exp_t e;
        e.chk_data = cd; e.data = ed; e.err = ee; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog act=%0d exp<150000", cyc);
            $display("test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
            $finish;
        end
    end

    initial begin
        int c0;
        logic [47:0] exp_stn;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        chk(err == 0 && stn_valid == 0, "R1 err/stn_valid", {err, stn_valid}, 0);
        chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1 lines", {ee_cs, ee_sk, ee_di}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 read, R2 command framing
        run(2'd0, 6'd3, 16'h0, 1, 16'h8001, 1'b0, "R3 read 3");
        chk(last_cmd == {3'b110, 6'd3}, "R2 read cmd", last_cmd, {3'b110, 6'd3});
        chk(last_gap == 0, "R2 read no gap clock", last_gap, 0);
        run(2'd0, 6'd63, 16'h0, 1, 16'h5A3C, 1'b0, "R3 read 63");

        // R5 write-enable
        run(2'd1, 6'd0, 16'h0, 0, 16'h0, 1'b0, "R5 wren");
        chk(last_cmd[8:4] == 5'b10011, "R5 wren cmd", last_cmd, 9'h130);
        chk(last_gap == 1, "R5 wren gap clock", last_gap, 1);

        // R4/R6 write, then read back
        run(2'd2, 6'd10, 16'hC3A5, 0, 16'h0, 1'b0, "R6 write");
        chk(last_cmd == {3'b101, 6'd10}, "R2 write cmd", last_cmd, {3'b101, 6'd10});
        chk(last_gap == 1, "R6 write gap clock", last_gap, 1);
        chk(last_poll_sk == 0, "R6 no clock in poll", last_poll_sk, 0);
        run(2'd0, 6'd10, 16'h0, 1, 16'hC3A5, 1'b0, "R4 write readback");

        // R6 erase
        run(2'd3, 6'd3, 16'h0, 0, 16'h0, 1'b0, "R6 erase");
        chk(last_cmd == {3'b111, 6'd3}, "R2 erase cmd", last_cmd, {3'b111, 6'd3});
        run(2'd0, 6'd3, 16'h0, 1, 16'hFFFF, 1'b0, "R6 erase readback");

        // R9 request while busy ignored
        c0 = cmd_count;
        begin
            exp_t e;
            e.chk_data = 1; e.data = 16'h5A3C; e.err = 1'b0; e.tag = "R9 read under strobe";
            q.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 6'd63;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 6'd63;
        boot_start = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; boot_start = 1'b0;
        chk(busy == 1, "R9 busy during access", busy, 1);
        wait_done();
        chk(cmd_count == c0 + 1, "R9 one command only", cmd_count - c0, 1);
        run(2'd0, 6'd63, 16'h0, 1, 16'h5A3C, 1'b0, "R9 word not erased");

        // R7 poll timeout, then cleared
        stall = 1'b1;
        run(2'd2, 6'd11, 16'h0F0F, 0, 16'h0, 1'b1, "R7 timeout err");
        chk(err == 1, "R7 err held", err, 1);
        stall = 1'b0;
        run(2'd0, 6'd11, 16'h0, 1, 16'h0F0F, 1'b0, "R7 err cleared");

        // R10 boot
        for (int k = 0; k < 3; k++) begin
            logic [15:0] w, p, t;
            w = mem[7 + k]; p = mem[6 + k];
            t = (w << 1) | (p >> 15);
            exp_stn[16*k +: 8]     = t[7:0];
            exp_stn[16*k + 8 +: 8] = w[14:7];
        end
        begin
            exp_t e;
            e.chk_data = 1; e.data = mem[9]; e.err = 1'b0; e.tag = "R10 boot last word";
            q.push_back(e);
        end
        c0 = cmd_count;
        @(negedge clk); boot_start = 1'b1;
        @(negedge clk); boot_start = 1'b0;
        wait_done();
        chk(stn_valid == 1, "R10 stn_valid", stn_valid, 1);
        chk(stn_addr == exp_stn, "R10 stn_addr", stn_addr, exp_stn);
        chk(cmd_count == c0 + 4, "R10 four reads", cmd_count - c0, 4);

        // R11 / R8 / R1 at end
        chk(sk_bad == 0 && sk_pulses > 0, "R11 sk high width", sk_bad, 0);
        chk({ee_cs, ee_sk, ee_di} == 3'b000, "R8 lines released", {ee_cs, ee_sk, ee_di}, 0);
        chk(q.size() == 0, "R9 all accesses completed", q.size(), 0);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end
endmodule